// File: doc/BRIEF.md
# PS/2 Mouse Movement Report Receiver

This block is the host-side receiver for a PS/2 pointing device. It watches the two open-collector lines (device clock and data), which both rest high between transfers, passes them through a synchroniser into the system clock domain, and takes one data sample on each falling edge of the device clock. Each 11-bit word (start 0, eight data bits least-significant first, odd parity, stop 1) is framed and checked. Three words in a row make one 33-bit movement report: a status byte, then the X magnitude, then the Y magnitude.

A good report produces a one-cycle `pkt_valid` strobe. On that same edge the block loads registered outputs: the two button states, 9-bit two's-complement X and Y deltas, and the two overflow flags. A report with any framing fault, or a status byte whose always-one bit is clear, is thrown away. The outputs keep their values and `pkt_err` pulses for one cycle instead. A stall timer restarts framing when the device clock stays high too long in the middle of a word or a report.

The framing machine has four states: `FR_IDLE` (wait for a start edge), `FR_DATA` (eight data edges), `FR_PARITY` and `FR_STOP`. It advances one state per falling edge and leaves `FR_STOP` for `FR_IDLE` when the word is complete. The report machine has three states: `AS_STATUS`, `AS_XMAG` and `AS_YMAG`. It advances one state per completed word and returns to `AS_STATUS` after the Y word. A stall timeout forces both machines back to their first state from any state.

Top module: `ps2_report_rx`

## Requirements
- R1: While reset is held and right after it is released, `pkt_valid` and `pkt_err` are 0, and `dx`, `dy`, `btn_left`, `btn_right`, `ovf_x` and `ovf_y` are all 0.
- R2: A word is read as one bit per falling edge of the device clock, in this order: a start bit that must be 0, eight data bits with the least-significant bit first, a parity bit that makes the nine data-plus-parity bits hold an odd count of ones, and a stop bit that must be 1. A high idle line produces no activity.
- R3: Three good words in a row (status, X, Y) give exactly one `pkt_valid` pulse within 8 system cycles after the 33rd falling edge.
- R4: Status bit 0 is loaded into `btn_left` and status bit 1 into `btn_right`.
- R5: `dx` = {status bit 4, X byte} and `dy` = {status bit 5, Y byte}, each a 9-bit two's-complement value. Status bit 2 has no effect.
- R6: Status bit 6 is loaded into `ovf_x` and status bit 7 into `ovf_y`.
- R7: A parity error in any of the three words gives one `pkt_err` pulse and no `pkt_valid`, and leaves every report output unchanged.
- R8: A start bit of 1 or a stop bit of 0 in any word is handled the same way as in R7.
- R9: A status byte with bit 3 equal to 0 is handled the same way as in R7.
- R10: If the device clock shows no falling edge for STALL_CYCLES system cycles while a word or a report is partly received, all partial state is dropped, and the next start bit begins the status word of a new report.
- R11: `pkt_valid` and `pkt_err` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Device clock line as received, asynchronous |
| ps2_dat_i | input | 1 | Device data line as received, asynchronous |
| btn_left | output | 1 | Left button from the last good report |
| btn_right | output | 1 | Right button from the last good report |
| dx | output | 9 | Signed X delta, right is positive |
| dy | output | 9 | Signed Y delta, up is positive |
| ovf_x | output | 1 | X movement overflowed its range |
| ovf_y | output | 1 | Y movement overflowed its range |
| pkt_valid | output | 1 | One-cycle strobe when a good report has been loaded |
| pkt_err | output | 1 | One-cycle strobe when a report has been discarded |

## Verification
The hardest case to reach from the ports is the stall recovery. Word and report framing have to be cut off partway, with no line level that shows the break. The stimulus sends a status word and an X word, then holds both lines idle longer than the stall limit, and then sends a complete report with different values. A second run stops a word after five bits. In both runs the only correct result is the second report's exact fields with no error pulse. Any byte slip left over from the broken transfer would instead show up as shifted fields or an error.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned DELTA_W = BYTE_W + 1;

    // Status byte bit positions; the device fixes this layout.
    localparam int unsigned ST_LEFT  = 0;
    localparam int unsigned ST_RIGHT = 1;
    localparam int unsigned ST_ONE   = 3;
    localparam int unsigned ST_XSIGN = 4;
    localparam int unsigned ST_YSIGN = 5;
    localparam int unsigned ST_XOVF  = 6;
    localparam int unsigned ST_YOVF  = 7;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_DATA   = 2'd1,
        FR_PARITY = 2'd2,
        FR_STOP   = 2'd3
    } frame_state_t;

    typedef enum logic [1:0] {
        AS_STATUS = 2'd0,
        AS_XMAG   = 2'd1,
        AS_YMAG   = 2'd2
    } asm_state_t;

    typedef struct packed {
        logic left;
        logic right;
        logic xsign;
        logic ysign;
        logic xovf;
        logic yovf;
    } status_t;

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_line,
    input  logic dat_line,
    output logic fall,
    output logic dat
);

    logic [STAGES-1:0] ck_sr;
    logic [STAGES-1:0] dt_sr;
    logic              ck_prev;

    // Both lines rest high, so reset to 1 to avoid a false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_sr   <= '1;
            dt_sr   <= '1;
            ck_prev <= 1'b1;
        end else begin
            ck_sr   <= {ck_sr[STAGES-2:0], clk_line};
            dt_sr   <= {dt_sr[STAGES-2:0], dat_line};
            ck_prev <= ck_sr[STAGES-1];
        end
    end

    assign fall = ck_prev & ~ck_sr[STAGES-1];
    assign dat  = dt_sr[STAGES-1];

endmodule

// File: rtl/ps2_stall_timer.sv
module ps2_stall_timer #(
    parameter int unsigned LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic fall,
    output logic timeout
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else if (!busy || fall || timeout) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            timeout <= 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
            timeout <= 1'b0;
        end
    end

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int unsigned DATA_BITS = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall,
    input  logic                 din,
    input  logic                 timeout,
    output logic                 word_done,
    output logic [DATA_BITS-1:0] word_byte,
    output logic                 word_ok,
    output logic                 busy
);

    localparam int unsigned CNT_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

    frame_state_t         st, nx;
    logic [CNT_W-1:0]     bit_cnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_acc;
    logic                 start_bad;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= FR_IDLE;
        else        st <= nx;
    end

    // next state: one step per falling edge, timeout wins
    always_comb begin
        nx = st;
        if (timeout) begin
            nx = FR_IDLE;
        end else if (fall) begin
            unique case (st)
                FR_IDLE:   nx = FR_DATA;
                FR_DATA:   nx = (bit_cnt == LAST_BIT) ? FR_PARITY : FR_DATA;
                FR_PARITY: nx = FR_STOP;
                FR_STOP:   nx = FR_IDLE;
            endcase
        end
    end

    // datapath and word outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            start_bad <= 1'b0;
            word_done <= 1'b0;
            word_byte <= '0;
            word_ok   <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (timeout) begin
                bit_cnt <= '0;
            end else if (fall) begin
                unique case (st)
                    FR_IDLE: begin
                        start_bad <= din;
                        par_acc   <= 1'b0;
                        bit_cnt   <= '0;
                    end
                    FR_DATA: begin
                        shreg   <= {din, shreg[DATA_BITS-1:1]};
                        par_acc <= par_acc ^ din;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    FR_PARITY: begin
                        par_acc <= par_acc ^ din;
                    end
                    FR_STOP: begin
                        word_done <= 1'b1;
                        word_byte <= shreg;
                        word_ok   <= ~start_bad & par_acc & din;
                    end
                endcase
            end
        end
    end

    assign busy = (st != FR_IDLE);

endmodule

// File: rtl/ps2_report_asm.sv
module ps2_report_asm
    import ps2rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_done,
    input  logic [BYTE_W-1:0]  word_byte,
    input  logic               word_ok,
    input  logic               timeout,
    output logic               mid_report,
    output logic               btn_left,
    output logic               btn_right,
    output logic [DELTA_W-1:0] dx,
    output logic [DELTA_W-1:0] dy,
    output logic               ovf_x,
    output logic               ovf_y,
    output logic               pkt_valid,
    output logic               pkt_err
);

    asm_state_t          st, nx;
    status_t             stat_q;
    logic [BYTE_W-1:0]   xmag_q;
    logic                bad_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= AS_STATUS;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        if (timeout) begin
            nx = AS_STATUS;
        end else if (word_done) begin
            unique case (st)
                AS_STATUS: nx = AS_XMAG;
                AS_XMAG:   nx = AS_YMAG;
                AS_YMAG:   nx = AS_STATUS;
                default:   nx = AS_STATUS;
            endcase
        end
    end

    // outputs and gathered fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= '0;
            xmag_q    <= '0;
            bad_q     <= 1'b0;
            btn_left  <= 1'b0;
            btn_right <= 1'b0;
            dx        <= '0;
            dy        <= '0;
            ovf_x     <= 1'b0;
            ovf_y     <= 1'b0;
            pkt_valid <= 1'b0;
            pkt_err   <= 1'b0;
        end else begin
            pkt_valid <= 1'b0;
            pkt_err   <= 1'b0;
            if (timeout) begin
                bad_q <= 1'b0;
            end else if (word_done) begin
                unique case (st)
                    AS_STATUS: begin
                        bad_q        <= ~word_ok | ~word_byte[ST_ONE];
                        stat_q.left  <= word_byte[ST_LEFT];
                        stat_q.right <= word_byte[ST_RIGHT];
                        stat_q.xsign <= word_byte[ST_XSIGN];
                        stat_q.ysign <= word_byte[ST_YSIGN];
                        stat_q.xovf  <= word_byte[ST_XOVF];
                        stat_q.yovf  <= word_byte[ST_YOVF];
                    end
                    AS_XMAG: begin
                        bad_q  <= bad_q | ~word_ok;
                        xmag_q <= word_byte;
                    end
                    AS_YMAG: begin
                        bad_q <= 1'b0;
                        if (bad_q || !word_ok) begin
                            pkt_err <= 1'b1;
                        end else begin
                            pkt_valid <= 1'b1;
                            btn_left  <= stat_q.left;
                            btn_right <= stat_q.right;
                            dx        <= {stat_q.xsign, xmag_q};
                            dy        <= {stat_q.ysign, word_byte};
                            ovf_x     <= stat_q.xovf;
                            ovf_y     <= stat_q.yovf;
                        end
                    end
                    default: bad_q <= 1'b0;
                endcase
            end
        end
    end

    assign mid_report = (st != AS_STATUS);

endmodule

// File: rtl/ps2_report_rx.sv
module ps2_report_rx
    import ps2rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned STALL_CYCLES = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ps2_clk_i,
    input  logic               ps2_dat_i,
    output logic               btn_left,
    output logic               btn_right,
    output logic [DELTA_W-1:0] dx,
    output logic [DELTA_W-1:0] dy,
    output logic               ovf_x,
    output logic               ovf_y,
    output logic               pkt_valid,
    output logic               pkt_err
);

    logic              fall_w;
    logic              dat_w;
    logic              timeout_w;
    logic              word_done_w;
    logic [BYTE_W-1:0] word_byte_w;
    logic              word_ok_w;
    logic              frame_busy_w;
    logic              mid_report_w;

    ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_line (ps2_clk_i),
        .dat_line (ps2_dat_i),
        .fall     (fall_w),
        .dat      (dat_w)
    );

    ps2_stall_timer #(.LIMIT(STALL_CYCLES)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (frame_busy_w | mid_report_w),
        .fall    (fall_w),
        .timeout (timeout_w)
    );

    ps2_frame_rx #(.DATA_BITS(BYTE_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall_w),
        .din       (dat_w),
        .timeout   (timeout_w),
        .word_done (word_done_w),
        .word_byte (word_byte_w),
        .word_ok   (word_ok_w),
        .busy      (frame_busy_w)
    );

    ps2_report_asm u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (word_done_w),
        .word_byte  (word_byte_w),
        .word_ok    (word_ok_w),
        .timeout    (timeout_w),
        .mid_report (mid_report_w),
        .btn_left   (btn_left),
        .btn_right  (btn_right),
        .dx         (dx),
        .dy         (dy),
        .ovf_x      (ovf_x),
        .ovf_y      (ovf_y),
        .pkt_valid  (pkt_valid),
        .pkt_err    (pkt_err)
    );

endmodule

// File: rtl/ps2rx_chk.sv
module ps2rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fall,
    input logic       word_done,
    input logic       frame_busy,
    input logic       timeout,
    input logic       pkt_valid,
    input logic       pkt_err,
    input logic       btn_left,
    input logic       btn_right,
    input logic [8:0] dx,
    input logic [8:0] dy,
    input logic       ovf_x,
    input logic       ovf_y
);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && pkt_err));

    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |=> !pkt_err);

    a_r2_word_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(fall));

    a_r3_valid_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(word_done));

    a_r7_err_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> $past(word_done));

    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> $stable({btn_left, btn_right, dx, dy, ovf_x, ovf_y}));

    a_r10_timeout_idles: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !frame_busy);

endmodule

bind ps2_report_rx ps2rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (fall_w),
    .word_done  (word_done_w),
    .frame_busy (frame_busy_w),
    .timeout    (timeout_w),
    .pkt_valid  (pkt_valid),
    .pkt_err    (pkt_err),
    .btn_left   (btn_left),
    .btn_right  (btn_right),
    .dx         (dx),
    .dy         (dy),
    .ovf_x      (ovf_x),
    .ovf_y      (ovf_y)
);

// File: tb/sim_ps2_report_rx.sv
`timescale 1ns/1ps
module sim_ps2_report_rx;

    localparam int HALF  = 20;   // device clock half period, system cycles
    localparam int GAP   = 60;   // idle between words
    localparam int STALL = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_ck = 1'b1;
    logic       ps2_dt = 1'b1;
    logic       btn_left, btn_right, ovf_x, ovf_y, pkt_valid, pkt_err;
    logic [8:0] dx, dy;

    int total = 0;
    int bad = 0;
    int n_valid = 0;
    int n_err = 0;
    int n_clash = 0;
    logic prev_v = 1'b0, prev_e = 1'b0;

    logic       e_l = 0, e_r = 0, e_ox = 0, e_oy = 0;
    logic [8:0] e_dx = '0, e_dy = '0;

    always #2 clk = ~clk;

    ps2_report_rx #(.SYNC_STAGES(2), .STALL_CYCLES(STALL)) u0 (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_ck), .ps2_dat_i(ps2_dt),
        .btn_left(btn_left), .btn_right(btn_right), .dx(dx), .dy(dy),
        .ovf_x(ovf_x), .ovf_y(ovf_y), .pkt_valid(pkt_valid), .pkt_err(pkt_err)
    );

    // R11 monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (pkt_valid) n_valid++;
            if (pkt_err) n_err++;
            if ((pkt_valid && pkt_err) || (pkt_valid && prev_v) || (pkt_err && prev_e))
                n_clash++;
        end
        prev_v <= pkt_valid;
        prev_e <= pkt_err;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ps2_bit(input logic v);
        @(negedge clk) ps2_dt = v;
        repeat (HALF) @(negedge clk);
        ps2_ck = 1'b0;
        repeat (HALF) @(negedge clk);
        ps2_ck = 1'b1;
    endtask

    task automatic send_word(input logic [7:0] b, input logic st,
                             input logic pflip, input logic sp, input int nbits);
        logic [10:0] bits;
        bits = {sp, (~^b) ^ pflip, b, st};
        for (int i = 0; i < nbits; i++) ps2_bit(bits[i]);
        @(negedge clk) ps2_dt = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    // which: 0 none, 1 parity, 2 start, 3 stop; word selects 0..2
    task automatic send_report(input logic [23:0] v, input int which, input int word);
        for (int w = 0; w < 3; w++) begin
            logic [7:0] b;
            b = v[23 - 8*w -: 8];
            send_word(b, (which == 2 && word == w), (which == 1 && word == w),
                      !(which == 3 && word == w), 11);
        end
    endtask

    task automatic check_report(input logic [23:0] v, input int which, input int word,
                                input string req);
        int v0, e0;
        logic good;
        v0 = n_valid; e0 = n_err;
        good = (which == 0) && v[16+3];
        send_report(v, which, word);
        repeat (8) @(negedge clk);
        if (good) begin
            e_l = v[16]; e_r = v[17];
            e_dx = {v[20], v[15:8]}; e_dy = {v[21], v[7:0]};
            e_ox = v[22]; e_oy = v[23];
        end
        chk({req, " valid count"}, n_valid - v0, good ? 1 : 0);
        chk({req, " err count"}, n_err - e0, good ? 0 : 1);
        chk("R4 btn_left", btn_left, e_l);
        chk("R4 btn_right", btn_right, e_r);
        chk("R5 dx", dx, e_dx);
        chk("R5 dy", dy, e_dy);
        chk("R6 ovf_x", ovf_x, e_ox);
        chk("R6 ovf_y", ovf_y, e_oy);
    endtask

    // {status, X, Y}
    localparam logic [23:0] VEC [0:5] = '{
        24'h08_05_03,
        24'h19_F0_10,
        24'h2A_7F_FF,
        24'hCB_00_80,
        24'h3C_81_01,
        24'h0B_AA_55
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 during reset
        chk("R1 pkt_valid in reset", pkt_valid, 0);
        chk("R1 dx in reset", dx, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pkt_valid", pkt_valid, 0);
        chk("R1 pkt_err", pkt_err, 0);
        chk("R1 dx", dx, 0);
        chk("R1 dy", dy, 0);
        chk("R1 buttons", {btn_left, btn_right}, 0);
        chk("R1 overflow", {ovf_x, ovf_y}, 0);
        // R2 idle lines give nothing
        repeat (200) @(negedge clk);
        chk("R2 idle no strobe", n_valid + n_err, 0);

        // R2 R3 R4 R5 R6 table walk
        for (int i = 0; i < 6; i++) check_report(VEC[i], 0, 0, "R3");

        // R7 parity faults
        check_report(24'h09_11_22, 1, 1, "R7");
        check_report(24'h09_11_22, 1, 0, "R7");
        check_report(24'h0A_44_66, 0, 0, "R3");
        // R8 bad start and bad stop
        check_report(24'h09_12_34, 2, 2, "R8");
        check_report(24'h09_12_34, 3, 0, "R8");
        // R9 status bit 3 clear
        check_report(24'h01_12_34, 0, 0, "R9");
        check_report(24'h09_12_34, 0, 0, "R3");

        // R10 stall after two words
        send_word(8'h09, 1'b0, 1'b0, 1'b1, 11);
        send_word(8'h77, 1'b0, 1'b0, 1'b1, 11);
        repeat (3 * STALL) @(negedge clk);
        check_report(24'h1A_06_07, 0, 0, "R10");
        // R10 stall mid-word
        send_word(8'h3B, 1'b0, 1'b0, 1'b1, 5);
        repeat (3 * STALL) @(negedge clk);
        check_report(24'h28_40_02, 0, 0, "R10");

        chk("R11 strobe overlap or width", n_clash, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule